// File: doc/BRIEF.md
# Length-Prefixed Stream Deframer

The block sits behind a bulk-transfer receive path and recovers Ethernet frames from a byte stream in which several frames are packed back to back. Bytes arrive one per cycle on a valid/ready input. A separate end flag marks the last byte of each bulk transfer. Every frame is preceded by a four-byte little-endian header. The header carries the frame length and, in a second field, the bitwise complement of that length as a self-check. The payload is followed by one pad byte whenever its length is odd, so that the next header starts on an even byte position.

Payload bytes pass straight through to an AXI4-Stream style byte output, with `tlast` (`out_last`) on the final byte of each frame. A stalled sink stalls the input, so no accepted byte is lost. Headers and payloads may straddle transfer boundaries. A header may be split only after its second byte. A malformed header or a badly placed transfer end produces a one-cycle error pulse with a cause code. A bad header also discards the rest of its transfer, and parsing resumes with a fresh header at the next transfer.

The controller has four states. `ST_HDR` collects header bytes. `ST_PAY` forwards payload. `ST_PAD` swallows the alignment byte. `ST_DROP` discards the rest of a transfer after a header error. The transitions are:
- `ST_HDR -> ST_PAY` on a fourth header byte that passes both checks.
- `ST_HDR -> ST_DROP` on a failing fourth byte that is not a transfer end.
- `ST_HDR -> ST_HDR` on a failing fourth byte that is a transfer end.
- `ST_PAY -> ST_HDR` after the last byte of an even frame, or of an odd frame that ends a transfer.
- `ST_PAY -> ST_PAD` after the last byte of an odd frame inside a transfer.
- `ST_PAD -> ST_HDR` on any byte.
- `ST_DROP -> ST_HDR` on a transfer-end byte.

Top module: `lpd_deframer`

## Requirements
- R1: The header is taken little-endian (first byte = bits 7:0). Its bits 10:0 give the payload length N. Exactly N payload bytes appear on the output, in input order, with `out_last` high on the N-th byte only.
- R2: Header bits 26:16 must equal the bitwise complement of bits 10:0. On a mismatch no payload is output and `err_code` = 1. The rest of that transfer is discarded, and a header is expected at the start of the next transfer.
- R3: A length of 0 or above 1514 (the `MAX_LEN` default) gives `err_code` = 2, with the same discard as R2. A length of exactly 1514 is accepted.
- R4: A transfer that ends right after the second header byte keeps those two bytes. The first two bytes of the next transfer complete the header, without error.
- R5: A payload that is not complete at a transfer end continues with the first byte of the next transfer. The remaining count is carried across.
- R6: After a payload of odd length, exactly one byte is skipped before the next header. After an even length, none is skipped.
- R7: A transfer end after the first or third header byte gives `err_code` = 3 and discards the partial header. An odd-length frame whose last payload byte ends a transfer is still delivered, but also gives `err_code` = 3. A transfer end after the fourth header byte is legal.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. Backpressure neither loses nor repeats payload bytes.
- R9: `err_valid` is high for exactly one cycle per error, in the cycle after the offending byte is accepted, and `err_code` is then 1, 2 or 3.
- R10: A synchronous active-high `rst` clears any partial header, the remaining count and the pad flag. During and after reset `in_ready` = 1, `out_valid` = 0 and `err_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input byte valid |
| in_end | input | 1 | Input byte is the last of its bulk transfer |
| in_ready | output | 1 | Block accepts the input byte |
| out_data | output | 8 | Recovered frame byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Output byte is the last of its frame |
| out_ready | input | 1 | Sink accepts the output byte |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 2 | Error cause: 1 check mismatch, 2 bad length, 3 bad transfer end |

## Verification
The bench sweeps frame lengths 1 to 24 across transfer sizes from 2 to 64 bytes, with and without output stalls. This forces split headers, payloads cut at every offset and pad bytes on both sides of a boundary. A design that kept a split header wrongly, skipped the pad after even frames, or lost count across a boundary would misparse every later header, and the run would show corrupted frames plus check-mismatch errors.

Directed cases send a corrupted check field, lengths 0, 1514 and 1515, transfer ends after one and three header bytes, and an unpadded odd frame at a transfer end. A wrong discard rule would leak junk bytes as frames, or lose the frame that follows. A reset in the middle of a split header must leave no half-header behind; if it did, the next frame's header would be misaligned and rejected.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PAY  = 2'd1,
        ST_PAD  = 2'd2,
        ST_DROP = 2'd3
    } lpd_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_CHECK = 2'd1,
        ERR_SIZE  = 2'd2,
        ERR_END   = 2'd3
    } lpd_err_e;

    localparam int HDR_BYTES = 4;

endpackage

// File: rtl/lpd_hdr_asm.sv
// Collects the four header bytes and judges the header while its last byte is on the input.
module lpd_hdr_asm #(
    parameter int LEN_W   = 11,
    parameter int MAX_LEN = 1514
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             clear,
    input  logic [7:0]       byte_in,
    output logic [1:0]       cnt,
    output logic [LEN_W-1:0] len,
    output logic             chk_ok,
    output logic             size_ok
);
    localparam int HI_W = LEN_W - 8;
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] len_q;
    logic [7:0]       chk_lo_q;
    logic [LEN_W-1:0] chk_full;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            chk_lo_q <= '0;
        end else if (take) begin
            case (cnt)
                2'd0:    len_q[7:0]       <= byte_in;
                2'd1:    len_q[LEN_W-1:8] <= byte_in[HI_W-1:0];
                2'd2:    chk_lo_q         <= byte_in;
                default: ;
            endcase
        end
    end

    // The check field's upper bits come from the byte being accepted now.
    assign len      = len_q;
    assign chk_full = {byte_in[HI_W-1:0], chk_lo_q};
    assign chk_ok   = (chk_full == ~len_q);
    assign size_ok  = (len_q != '0) && (len_q <= MAX_L);

    // R7: a partial header is only dropped when a byte is actually accepted
    a_r7_clear_with_take: assert property (@(posedge clk) disable iff (rst)
        clear |-> take);

endmodule

// File: rtl/lpd_rem_cnt.sv
// Payload bytes still owed for the current frame; survives transfer boundaries.
module lpd_rem_cnt #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] rem,
    output logic             is_last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (dec) begin
            rem <= rem - ONE;
        end
    end

    assign is_last = (rem == ONE);

    // R1: never count a byte that was not owed
    a_r1_dec_nonzero: assert property (@(posedge clk) disable iff (rst)
        dec |-> (rem != '0));

    // R1: a new frame is only started once the previous one is fully counted
    a_r1_load_when_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> (rem == '0));

endmodule

// File: rtl/lpd_deframer.sv
module lpd_deframer
    import lpd_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MAX_LEN = 1514
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_end,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready,
    output logic       err_valid,
    output logic [1:0] err_code
);
    localparam logic [1:0] LAST_HDR_IDX = 2'(HDR_BYTES - 1);
    localparam logic [1:0] HALF_HDR_IDX = 2'(HDR_BYTES / 2 - 1);

    lpd_state_e       state, state_n;
    lpd_err_e         err_n;
    logic             odd_q, odd_n;
    logic             acc;
    logic             hdr_take, hdr_clear;
    logic [1:0]       hcnt;
    logic [LEN_W-1:0] hdr_len;
    logic             chk_ok, size_ok;
    logic             cnt_load, cnt_dec;
    logic [LEN_W-1:0] rem;
    logic             is_last;

    assign in_ready  = (state == ST_PAY) ? out_ready : 1'b1;
    assign acc       = in_valid && in_ready;
    assign hdr_take  = (state == ST_HDR) && acc;
    assign out_data  = in_data;
    assign out_valid = (state == ST_PAY) && in_valid;
    assign out_last  = out_valid && is_last;

    lpd_hdr_asm #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_hdr (
        .clk     (clk),
        .rst     (rst),
        .take    (hdr_take),
        .clear   (hdr_clear),
        .byte_in (in_data),
        .cnt     (hcnt),
        .len     (hdr_len),
        .chk_ok  (chk_ok),
        .size_ok (size_ok)
    );

    lpd_rem_cnt #(
        .LEN_W (LEN_W)
    ) u_rem (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (hdr_len),
        .dec      (cnt_dec),
        .rem      (rem),
        .is_last  (is_last)
    );

    always_comb begin
        state_n   = state;
        err_n     = ERR_NONE;
        odd_n     = odd_q;
        hdr_clear = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        unique case (state)
            ST_HDR: begin
                if (acc) begin
                    if (hcnt == LAST_HDR_IDX) begin
                        if (!chk_ok) begin
                            err_n   = ERR_CHECK;
                            state_n = in_end ? ST_HDR : ST_DROP;
                        end else if (!size_ok) begin
                            err_n   = ERR_SIZE;
                            state_n = in_end ? ST_HDR : ST_DROP;
                        end else begin
                            cnt_load = 1'b1;
                            odd_n    = hdr_len[0];
                            state_n  = ST_PAY;
                        end
                    end else if (in_end && (hcnt != HALF_HDR_IDX)) begin
                        err_n     = ERR_END;
                        hdr_clear = 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (acc) begin
                    cnt_dec = 1'b1;
                    if (is_last) begin
                        if (odd_q && in_end) begin
                            err_n   = ERR_END;
                            state_n = ST_HDR;
                        end else if (odd_q) begin
                            state_n = ST_PAD;
                        end else begin
                            state_n = ST_HDR;
                        end
                    end
                end
            end
            ST_PAD: begin
                if (acc) begin
                    state_n = ST_HDR;
                end
            end
            ST_DROP: begin
                if (acc && in_end) begin
                    state_n = ST_HDR;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HDR;
            odd_q <= 1'b0;
        end else begin
            state <= state_n;
            odd_q <= odd_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= (err_n != ERR_NONE);
            err_code  <= err_n;
        end
    end

    // R8: a stalled sink must stall the source
    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: a pulse always carries a cause
    a_r9_err_code_set: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code != 2'd0));

    // R4: header collection is idle while payload is forwarded
    a_r4_hdr_idle_in_payload: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAY) |-> (hcnt == 2'd0));

    // R1: output only while bytes are still owed
    a_r1_output_owed: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rem != '0));

    // R6: the pad state is entered only after an odd-length frame
    a_r6_pad_after_odd: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD) |-> odd_q);

endmodule

// File: tb/lpd_deframer_bench.sv
`timescale 1ns/1ps
module lpd_deframer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_end;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_ready = 1'b1;
    logic       err_valid;
    logic [1:0] err_code;

    always #4 clk = ~clk;

    lpd_deframer u_lpd_deframer (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_end    (in_end),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_ready (out_ready),
        .err_valid (err_valid),
        .err_code  (err_code)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rdy_mode = 0;

    logic [7:0] sb [0:4095];
    logic       se [0:4095];
    int         sn;
    logic [8:0] ev [0:4095];
    int         en;
    logic [8:0] gv [0:4095];
    int         gn;
    int         gerr [0:63];
    int         gerr_n;
    int         xerr [0:63];
    int         xn;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got hang, expected completion");
            summary();
            $finish;
        end
    end

    always @(posedge clk) begin
        #2;
        out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (gn < 4096) gv[gn] = {out_last, out_data};
                gn++;
            end
            if (err_valid) begin
                if (gerr_n < 64) gerr[gerr_n] = int'(err_code);
                gerr_n++;
            end
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic clear_logs();
        sn = 0; en = 0; gn = 0; gerr_n = 0; xn = 0;
    endtask

    task automatic push(logic [7:0] b, logic e);
        sb[sn] = b;
        se[sn] = e;
        sn++;
    endtask

    task automatic end_here();
        se[sn-1] = 1'b1;
    endtask

    task automatic expect_err(int code);
        xerr[xn] = code;
        xn++;
    endtask

    task automatic push_hdr(int len, bit good);
        logic [10:0] l;
        logic [10:0] c;
        l = 11'(len);
        c = good ? ~l : (~l ^ 11'h004);
        push(l[7:0], 1'b0);
        push({5'b0, l[10:8]}, 1'b0);
        push(c[7:0], 1'b0);
        push({5'b0, c[10:8]}, 1'b0);
    endtask

    function automatic logic [7:0] pbyte(int seed, int i);
        return 8'(seed * 29 + i * 7 + (i >> 3));
    endfunction

    task automatic add_frame(int len, int seed, bit padit);
        logic [7:0] b;
        push_hdr(len, 1'b1);
        for (int i = 0; i < len; i++) begin
            b = pbyte(seed, i);
            push(b, 1'b0);
            ev[en] = {(i == len - 1), b};
            en++;
        end
        if ((len % 2 == 1) && padit) push(8'hA5, 1'b0);
    endtask

    task automatic set_ends(int t);
        for (int i = 0; i < sn; i++) se[i] = (((i + 1) % t) == 0) || (i == sn - 1);
    endtask

    task automatic drive_all();
        for (int i = 0; i < sn; i++) begin
            in_data  = sb[i];
            in_end   = se[i];
            in_valid = 1'b1;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_end   = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic verify(string req);
        chk(req, "frame byte count", gn, en);
        for (int i = 0; i < en && i < gn; i++)
            chk(req, "byte {last,data}", int'(gv[i]), int'(ev[i]));
        chk(req, "error count", gerr_n, xn);
        for (int i = 0; i < xn && i < gerr_n; i++)
            chk(req, "error code", gerr[i], xerr[i]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int sizes [6];
        sizes = '{2, 4, 6, 10, 16, 64};
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h00;
        in_end = 1'b0;
        clear_logs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports
        chk("R10", "in_ready in reset", int'(in_ready), 1);
        chk("R10", "out_valid in reset", int'(out_valid), 0);
        chk("R10", "err_valid in reset", int'(err_valid), 0);
        in_valid = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #1;

        // R1 R4 R5 R6 R8: sweep of lengths over transfer sizes and stall patterns
        for (int rm = 0; rm < 2; rm++) begin
            rdy_mode = rm;
            for (int s = 0; s < 6; s++) begin
                clear_logs();
                for (int l = 1; l <= 24; l++) add_frame(l, l + sizes[s], 1'b1);
                set_ends(sizes[s]);
                drive_all();
                verify(rm == 0 ? "R1,R4,R5,R6" : "R1,R5,R6,R8");
            end
        end
        rdy_mode = 0;

        // R2 R9: bad check field, junk discarded up to the transfer end
        clear_logs();
        push_hdr(6, 1'b0);
        for (int i = 0; i < 4; i++) push(8'(8'h30 + i), 1'b0);
        end_here();
        add_frame(5, 3, 1'b1);
        end_here();
        expect_err(1);
        drive_all();
        verify("R2,R9");

        // R3: oversize length
        clear_logs();
        push_hdr(1515, 1'b1);
        push(8'h11, 1'b0);
        push(8'h22, 1'b0);
        end_here();
        add_frame(8, 4, 1'b1);
        end_here();
        expect_err(2);
        drive_all();
        verify("R3 oversize");

        // R3: zero length with a valid check, ending its transfer
        clear_logs();
        push_hdr(0, 1'b1);
        end_here();
        add_frame(3, 6, 1'b1);
        end_here();
        expect_err(2);
        drive_all();
        verify("R3 zero");

        // R3: largest legal length
        clear_logs();
        add_frame(1514, 9, 1'b1);
        end_here();
        drive_all();
        verify("R3 max");

        // R7: transfer end after one header byte
        clear_logs();
        push(8'h04, 1'b1);
        add_frame(4, 11, 1'b1);
        end_here();
        expect_err(3);
        drive_all();
        verify("R7 one byte");

        // R7: transfer end after three header bytes
        clear_logs();
        push(8'h04, 1'b0);
        push(8'h00, 1'b0);
        push(8'hFB, 1'b1);
        add_frame(7, 12, 1'b1);
        end_here();
        expect_err(3);
        drive_all();
        verify("R7 three bytes");

        // R7: odd frame ending its transfer without pad is delivered and flagged
        clear_logs();
        add_frame(3, 5, 1'b0);
        end_here();
        add_frame(2, 13, 1'b1);
        end_here();
        expect_err(3);
        drive_all();
        verify("R7 unpadded");

        // R7: transfer end right after a complete header is legal
        clear_logs();
        add_frame(6, 14, 1'b1);
        se[3] = 1'b1;
        end_here();
        drive_all();
        verify("R7 full header end");

        // R10: reset in the middle of a split header
        clear_logs();
        push(8'h09, 1'b0);
        push(8'h00, 1'b1);
        drive_all();
        do_reset();
        clear_logs();
        add_frame(7, 15, 1'b1);
        end_here();
        drive_all();
        verify("R10 mid-header reset");

        summary();
        $finish;
    end

endmodule